// File: doc/BRIEF.md
# Decoupled Bypass Power-State Controller

This per-node block sits between a network interface, its local router and a pair of ring ports. It lets the interface keep sending and receiving flits while the router is powered down. A flit entering the ring input port is handed straight to the interface's ejection side. A flit the interface injects goes straight out of the ring output port. Chained across all nodes, these two paths form a ring that links every interface whatever power state its router is in.

The block also chooses the router's power state. The router drops to OFF as soon as its datapath is empty and no packet is part-way across its local ports. Waking is driven by local demand. Virtual-channel request pulses from the interface are counted over fixed tumbling windows. When a window's total exceeds a threshold, the router enters WAKING and, after a set number of cycles, ON. A class input, fixed outside the block, picks the threshold. The low threshold serves routers that should wake early and the high one serves routers that should stay dark longer. Because the ring paths stay live throughout WAKING, no packet ever waits on the router.

Top module: `pg_bypass_ctrl`

## Requirements
- R1: After reset the power state is OFF and `pwr_en` is low. `pwr_state` is encoded as OFF = 2'b00, WAKING = 2'b01 and ON = 2'b10.
- R2: While the state is not ON, the ring input feeds the ejection side in the same cycle. `ni_ej_valid`/`ni_ej_data` follow `byp_in_valid`/`byp_in_data`, `byp_in_ready` equals `ni_ej_ready`, and `rtr_ej_ready` is low.
- R3: While the state is not ON, injection feeds the ring output in the same cycle. `byp_out_valid`/`byp_out_data` follow `ni_inj_valid`/`ni_inj_data`, `ni_inj_ready` equals `byp_out_ready`, and `rtr_inj_valid` is low.
- R4: `vc_req` pulses are summed over tumbling windows of WIN (32) cycles. The first window covers the first WIN clock edges after reset release. If the state is OFF and a window's total exceeds the threshold, the state becomes WAKING on the window's last edge.
- R5: `perf_class` = 1 selects THR_LO (4) and `perf_class` = 0 selects THR_HI (12). The comparison is strictly greater-than, so a total equal to the threshold does not wake the router.
- R6: WAKING lasts exactly WAKE_CYC (8) cycles and then turns into ON. `pwr_en` is high in WAKING and ON and low in OFF.
- R7: In ON, once no partial packet remains on the ring paths, injection connects to the router input (`rtr_inj_*`) and the router output (`rtr_ej_*`) connects to ejection. The ring input is then held not ready and the ring output is held not valid.
- R8: Bit FLIT_W-1 of every flit marks the tail. A ring path that has carried a non-tail flit without its tail keeps that path on the ring after ON is reached, until the tail flit has passed. Each direction is handled separately.
- R9: ON turns into OFF on an edge where `rtr_empty` is high, no partial packet is open on the router-side local paths, and no router-side transfer happens in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| perf_class | input | 1 | 1 = early-wake class (low threshold), 0 = late-wake class |
| vc_req | input | 1 | One virtual-channel request at the local interface this cycle |
| rtr_empty | input | 1 | Router datapath holds no flit |
| byp_in_valid | input | 1 | Ring input flit valid |
| byp_in_ready | output | 1 | Ring input flit accepted |
| byp_in_data | input | FLIT_W | Ring input flit, MSB = tail |
| byp_out_valid | output | 1 | Ring output flit valid |
| byp_out_ready | input | 1 | Next node accepts ring flit |
| byp_out_data | output | FLIT_W | Ring output flit |
| ni_inj_valid | input | 1 | Interface injection flit valid |
| ni_inj_ready | output | 1 | Injection flit accepted |
| ni_inj_data | input | FLIT_W | Injection flit, MSB = tail |
| ni_ej_valid | output | 1 | Ejection flit valid to interface |
| ni_ej_ready | input | 1 | Interface accepts ejection flit |
| ni_ej_data | output | FLIT_W | Ejection flit |
| rtr_inj_valid | output | 1 | Flit valid into router local input |
| rtr_inj_ready | input | 1 | Router local input accepts |
| rtr_inj_data | output | FLIT_W | Flit into router local input |
| rtr_ej_valid | input | 1 | Router local output flit valid |
| rtr_ej_ready | output | 1 | Router local output flit accepted |
| rtr_ej_data | input | FLIT_W | Router local output flit, MSB = tail |
| pwr_state | output | 2 | Power state (OFF 00, WAKING 01, ON 10) |
| pwr_en | output | 1 | Router supply enable |

## Verification
Two events can land on the same edge: the end of WAKING and a ring injection packet that is still open. The bench opens an injection packet on the ring while the router is OFF and then crosses a window threshold to wake it. It then shows that, once ON, injection stays on the ring port while ejection has already moved to the router port. Only after the tail flit leaves does injection switch to the router. In the same way, a power-off request is raised while a router-side packet is open and while its tail is moving, and the bench shows that OFF is reached only on the first fully quiet edge.

// File: rtl/pgb_pkg.sv
package pgb_pkg;
   typedef enum logic [1:0] {
      PS_OFF  = 2'b00,
      PS_WAKE = 2'b01,
      PS_ON   = 2'b10
   } pstate_e;
endpackage

// File: rtl/pgb_rate_win.sv
module pgb_rate_win #(
   parameter int WIN    = 32,
   parameter int THR_LO = 4,
   parameter int THR_HI = 12
) (
   input  logic clk,
   input  logic rst_n,
   input  logic vc_req,
   input  logic perf_class,
   output logic wake_req
);
   localparam int PW = $clog2(WIN);
   localparam int CW = $clog2(WIN + 1);

   logic [PW-1:0] pos;
   logic [CW-1:0] cnt;
   logic [CW-1:0] tot;
   logic [CW-1:0] thr;
   logic          win_end;

   assign tot = cnt + CW'(vc_req);
   assign thr = perf_class ? CW'(THR_LO) : CW'(THR_HI);

   generate
      if ((1 << PW) == WIN) begin : g_pow2
         assign win_end = &pos;
         always_ff @(posedge clk) begin
            if (!rst_n) pos <= '0;
            else        pos <= pos + 1'b1;
         end
      end else begin : g_mod
         assign win_end = (pos == PW'(WIN - 1));
         always_ff @(posedge clk) begin
            if (!rst_n)       pos <= '0;
            else if (win_end) pos <= '0;
            else              pos <= pos + 1'b1;
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)       cnt <= '0;
      else if (win_end) cnt <= '0;
      else              cnt <= tot;
   end

   assign wake_req = win_end && (tot > thr);
endmodule

// File: rtl/pgb_pwr_fsm.sv
module pgb_pwr_fsm
   import pgb_pkg::*;
#(
   parameter int WAKE_CYC = 8
) (
   input  logic    clk,
   input  logic    rst_n,
   input  logic    wake_req,
   input  logic    rtr_quiet,
   output pstate_e state
);
   localparam int TW = (WAKE_CYC > 1) ? $clog2(WAKE_CYC) : 1;

   logic [TW-1:0] tmr;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= PS_OFF;
         tmr   <= '0;
      end else begin
         unique case (state)
            PS_OFF: begin
               if (wake_req) begin
                  state <= PS_WAKE;
                  tmr   <= TW'(WAKE_CYC - 1);
               end
            end
            PS_WAKE: begin
               if (tmr == '0) state <= PS_ON;
               else           tmr   <= tmr - 1'b1;
            end
            PS_ON: begin
               if (rtr_quiet) state <= PS_OFF;
            end
            default: state <= PS_OFF;
         endcase
      end
   end
endmodule

// File: rtl/pgb_pkt_track.sv
module pgb_pkt_track (
   input  logic clk,
   input  logic rst_n,
   input  logic fire,
   input  logic tail,
   output logic mid
);
   always_ff @(posedge clk) begin
      if (!rst_n)    mid <= 1'b0;
      else if (fire) mid <= !tail;
   end
endmodule

// File: rtl/pgb_steer.sv
module pgb_steer
   import pgb_pkg::*;
#(
   parameter int FLIT_W = 34
) (
   input  logic              clk,
   input  logic              rst_n,
   input  pstate_e           state,
   input  logic              rtr_empty,
   input  logic              byp_in_valid,
   output logic              byp_in_ready,
   input  logic [FLIT_W-1:0] byp_in_data,
   output logic              byp_out_valid,
   input  logic              byp_out_ready,
   output logic [FLIT_W-1:0] byp_out_data,
   input  logic              ni_inj_valid,
   output logic              ni_inj_ready,
   input  logic [FLIT_W-1:0] ni_inj_data,
   output logic              ni_ej_valid,
   input  logic              ni_ej_ready,
   output logic [FLIT_W-1:0] ni_ej_data,
   output logic              rtr_inj_valid,
   input  logic              rtr_inj_ready,
   output logic [FLIT_W-1:0] rtr_inj_data,
   input  logic              rtr_ej_valid,
   output logic              rtr_ej_ready,
   input  logic [FLIT_W-1:0] rtr_ej_data,
   output logic              rtr_quiet
);
   localparam int TAIL   = FLIT_W - 1;
   localparam int NTRK   = 4;
   localparam int T_BINJ = 0;
   localparam int T_BEJ  = 1;
   localparam int T_RINJ = 2;
   localparam int T_REJ  = 3;

   logic [NTRK-1:0] fire;
   logic [NTRK-1:0] tail;
   logic [NTRK-1:0] mid;
   logic            powered;
   logic            inj_byp;
   logic            ej_byp;

   assign powered = (state == PS_ON);
   assign inj_byp = !powered || mid[T_BINJ];
   assign ej_byp  = !powered || mid[T_BEJ];

   // injection direction
   assign byp_out_valid = ni_inj_valid && inj_byp;
   assign rtr_inj_valid = ni_inj_valid && !inj_byp;
   assign byp_out_data  = ni_inj_data;
   assign rtr_inj_data  = ni_inj_data;
   assign ni_inj_ready  = inj_byp ? byp_out_ready : rtr_inj_ready;

   // ejection direction
   assign ni_ej_valid  = ej_byp ? byp_in_valid : rtr_ej_valid;
   assign ni_ej_data   = ej_byp ? byp_in_data  : rtr_ej_data;
   assign byp_in_ready = ej_byp && ni_ej_ready;
   assign rtr_ej_ready = !ej_byp && ni_ej_ready;

   assign fire[T_BINJ] = byp_out_valid && byp_out_ready;
   assign fire[T_BEJ]  = byp_in_valid  && byp_in_ready;
   assign fire[T_RINJ] = rtr_inj_valid && rtr_inj_ready;
   assign fire[T_REJ]  = rtr_ej_valid  && rtr_ej_ready;
   assign tail[T_BINJ] = ni_inj_data[TAIL];
   assign tail[T_BEJ]  = byp_in_data[TAIL];
   assign tail[T_RINJ] = ni_inj_data[TAIL];
   assign tail[T_REJ]  = rtr_ej_data[TAIL];

   generate
      for (genvar g = 0; g < NTRK; g++) begin : g_trk
         pgb_pkt_track u_trk (
            .clk   (clk),
            .rst_n (rst_n),
            .fire  (fire[g]),
            .tail  (tail[g]),
            .mid   (mid[g])
         );
      end
   endgenerate

   assign rtr_quiet = rtr_empty && !mid[T_RINJ] && !mid[T_REJ]
                      && !fire[T_RINJ] && !fire[T_REJ];
endmodule

// File: rtl/pg_bypass_ctrl.sv
module pg_bypass_ctrl
   import pgb_pkg::*;
#(
   parameter int FLIT_W   = 34,
   parameter int WIN      = 32,
   parameter int THR_LO   = 4,
   parameter int THR_HI   = 12,
   parameter int WAKE_CYC = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              perf_class,
   input  logic              vc_req,
   input  logic              rtr_empty,
   input  logic              byp_in_valid,
   output logic              byp_in_ready,
   input  logic [FLIT_W-1:0] byp_in_data,
   output logic              byp_out_valid,
   input  logic              byp_out_ready,
   output logic [FLIT_W-1:0] byp_out_data,
   input  logic              ni_inj_valid,
   output logic              ni_inj_ready,
   input  logic [FLIT_W-1:0] ni_inj_data,
   output logic              ni_ej_valid,
   input  logic              ni_ej_ready,
   output logic [FLIT_W-1:0] ni_ej_data,
   output logic              rtr_inj_valid,
   input  logic              rtr_inj_ready,
   output logic [FLIT_W-1:0] rtr_inj_data,
   input  logic              rtr_ej_valid,
   output logic              rtr_ej_ready,
   input  logic [FLIT_W-1:0] rtr_ej_data,
   output logic [1:0]        pwr_state,
   output logic              pwr_en
);
   generate
      if (FLIT_W < 2) begin : g_bad_flit
         $error("FLIT_W must leave room for a tail bit and payload");
      end
      if (WIN < 2) begin : g_bad_win
         $error("WIN must be at least 2");
      end
      if (THR_LO > THR_HI) begin : g_bad_thr
         $error("THR_LO must not exceed THR_HI");
      end
      if (THR_HI >= WIN) begin : g_bad_hi
         $error("THR_HI must be below WIN or waking is impossible");
      end
      if (WAKE_CYC < 1) begin : g_bad_wake
         $error("WAKE_CYC must be at least 1");
      end
   endgenerate

   pstate_e state;
   logic    wake_req;
   logic    rtr_quiet;

   pgb_rate_win #(
      .WIN    (WIN),
      .THR_LO (THR_LO),
      .THR_HI (THR_HI)
   ) u_rate (
      .clk        (clk),
      .rst_n      (rst_n),
      .vc_req     (vc_req),
      .perf_class (perf_class),
      .wake_req   (wake_req)
   );

   pgb_pwr_fsm #(
      .WAKE_CYC (WAKE_CYC)
   ) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .wake_req  (wake_req),
      .rtr_quiet (rtr_quiet),
      .state     (state)
   );

   pgb_steer #(
      .FLIT_W (FLIT_W)
   ) u_steer (
      .clk           (clk),
      .rst_n         (rst_n),
      .state         (state),
      .rtr_empty     (rtr_empty),
      .byp_in_valid  (byp_in_valid),
      .byp_in_ready  (byp_in_ready),
      .byp_in_data   (byp_in_data),
      .byp_out_valid (byp_out_valid),
      .byp_out_ready (byp_out_ready),
      .byp_out_data  (byp_out_data),
      .ni_inj_valid  (ni_inj_valid),
      .ni_inj_ready  (ni_inj_ready),
      .ni_inj_data   (ni_inj_data),
      .ni_ej_valid   (ni_ej_valid),
      .ni_ej_ready   (ni_ej_ready),
      .ni_ej_data    (ni_ej_data),
      .rtr_inj_valid (rtr_inj_valid),
      .rtr_inj_ready (rtr_inj_ready),
      .rtr_inj_data  (rtr_inj_data),
      .rtr_ej_valid  (rtr_ej_valid),
      .rtr_ej_ready  (rtr_ej_ready),
      .rtr_ej_data   (rtr_ej_data),
      .rtr_quiet     (rtr_quiet)
   );

   assign pwr_state = state;
   assign pwr_en    = (state != PS_OFF);
endmodule

// File: rtl/pg_bypass_ctrl_chk.sv
module pg_bypass_ctrl_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       rtr_empty,
   input logic [1:0] pwr_state,
   input logic       byp_in_valid,
   input logic       ni_ej_valid,
   input logic       ni_inj_valid,
   input logic       byp_out_valid,
   input logic       byp_out_ready,
   input logic       byp_out_tail,
   input logic       rtr_inj_valid
);
   localparam logic [1:0] S_OFF  = 2'b00;
   localparam logic [1:0] S_WAKE = 2'b01;
   localparam logic [1:0] S_ON   = 2'b10;

   p_legal_state_r1: assert property (@(posedge clk) disable iff (!rst_n)
      pwr_state != 2'b11);

   p_ej_ring_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (pwr_state != S_ON) |-> (ni_ej_valid == byp_in_valid));

   p_inj_ring_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (pwr_state != S_ON) |-> (byp_out_valid == ni_inj_valid && !rtr_inj_valid));

   p_off_exit_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (pwr_state == S_OFF) |=> (pwr_state == S_OFF || pwr_state == S_WAKE));

   p_wake_exit_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (pwr_state == S_WAKE) |=> (pwr_state != S_OFF));

   p_no_split_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (pwr_state == S_ON && byp_out_valid && byp_out_ready && !byp_out_tail)
      |=> !rtr_inj_valid);

   p_busy_stays_on_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (pwr_state == S_ON && !rtr_empty) |=> (pwr_state != S_OFF));
endmodule

bind pg_bypass_ctrl pg_bypass_ctrl_chk u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .rtr_empty     (rtr_empty),
   .pwr_state     (pwr_state),
   .byp_in_valid  (byp_in_valid),
   .ni_ej_valid   (ni_ej_valid),
   .ni_inj_valid  (ni_inj_valid),
   .byp_out_valid (byp_out_valid),
   .byp_out_ready (byp_out_ready),
   .byp_out_tail  (byp_out_data[FLIT_W-1]),
   .rtr_inj_valid (rtr_inj_valid)
);

// File: tb/pg_bypass_ctrl_tb.sv
module pg_bypass_ctrl_tb;
   localparam int FW   = 34;
   localparam int WIN  = 32;
   localparam int TLO  = 4;
   localparam int THI  = 12;
   localparam int WAKE = 8;
   localparam logic [1:0] S_OFF  = 2'b00;
   localparam logic [1:0] S_WAKE = 2'b01;
   localparam logic [1:0] S_ON   = 2'b10;

   // {class, expect_wake, request count[5:0]}
   localparam int NV = 6;
   localparam logic [7:0] VEC [0:NV-1] = '{
      {1'b0, 1'b0, 6'd12},
      {1'b0, 1'b1, 6'd13},
      {1'b1, 1'b0, 6'd4},
      {1'b1, 1'b1, 6'd5},
      {1'b1, 1'b0, 6'd0},
      {1'b0, 1'b1, 6'd32}
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          perf_class = 1'b0;
   logic          vc_req = 1'b0;
   logic          rtr_empty = 1'b0;
   logic          byp_in_valid = 1'b0;
   logic          byp_in_ready;
   logic [FW-1:0] byp_in_data = '0;
   logic          byp_out_valid;
   logic          byp_out_ready = 1'b0;
   logic [FW-1:0] byp_out_data;
   logic          ni_inj_valid = 1'b0;
   logic          ni_inj_ready;
   logic [FW-1:0] ni_inj_data = '0;
   logic          ni_ej_valid;
   logic          ni_ej_ready = 1'b0;
   logic [FW-1:0] ni_ej_data;
   logic          rtr_inj_valid;
   logic          rtr_inj_ready = 1'b0;
   logic [FW-1:0] rtr_inj_data;
   logic          rtr_ej_valid = 1'b0;
   logic          rtr_ej_ready;
   logic [FW-1:0] rtr_ej_data = '0;
   logic [1:0]    pwr_state;
   logic          pwr_en;

   int checks = 0;
   int errors = 0;
   int edges  = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   always @(posedge clk) if (rst_n) edges <= edges + 1;

   pg_bypass_ctrl #(
      .FLIT_W (FW), .WIN (WIN), .THR_LO (TLO), .THR_HI (THI), .WAKE_CYC (WAKE)
   ) u_dut (
      .clk (clk), .rst_n (rst_n), .perf_class (perf_class), .vc_req (vc_req),
      .rtr_empty (rtr_empty),
      .byp_in_valid (byp_in_valid), .byp_in_ready (byp_in_ready), .byp_in_data (byp_in_data),
      .byp_out_valid (byp_out_valid), .byp_out_ready (byp_out_ready), .byp_out_data (byp_out_data),
      .ni_inj_valid (ni_inj_valid), .ni_inj_ready (ni_inj_ready), .ni_inj_data (ni_inj_data),
      .ni_ej_valid (ni_ej_valid), .ni_ej_ready (ni_ej_ready), .ni_ej_data (ni_ej_data),
      .rtr_inj_valid (rtr_inj_valid), .rtr_inj_ready (rtr_inj_ready), .rtr_inj_data (rtr_inj_data),
      .rtr_ej_valid (rtr_ej_valid), .rtr_ej_ready (rtr_ej_ready), .rtr_ej_data (rtr_ej_data),
      .pwr_state (pwr_state), .pwr_en (pwr_en)
   );

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic align();
      while (edges % WIN != 0) @(negedge clk);
   endtask

   task automatic run_window(input logic cls, input int n);
      perf_class = cls;
      for (int i = 0; i < WIN; i++) begin
         vc_req = (i < n);
         @(negedge clk);
      end
      vc_req = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      check("R1 state", pwr_state, S_OFF);
      check("R1 pwr_en", pwr_en, 1'b0);
      rst_n = 1'b1;

      // table walk: R4 window, R5 thresholds, R6 wake length, R9 turn-off
      for (int v = 0; v < NV; v++) begin
         align();
         run_window(VEC[v][7], int'(VEC[v][5:0]));
         if (VEC[v][6]) begin
            check("R4 woke", pwr_state, S_WAKE);
            repeat (WAKE - 1) @(negedge clk);
            check("R6 still waking", pwr_state, S_WAKE);
            check("R6 pwr_en waking", pwr_en, 1'b1);
            @(negedge clk);
            check("R6 on", pwr_state, S_ON);
            rtr_empty = 1'b1;
            @(negedge clk);
            check("R9 off when empty", pwr_state, S_OFF);
            check("R6 pwr_en off", pwr_en, 1'b0);
            rtr_empty = 1'b0;
         end else begin
            check("R5 no wake at or under threshold", pwr_state, S_OFF);
         end
      end

      // R2/R3: ring paths in OFF
      byp_in_valid = 1'b1; byp_in_data = {1'b1, 33'h0AB1};
      ni_ej_ready = 1'b1;
      ni_inj_valid = 1'b1; ni_inj_data = {1'b1, 33'h0CD2};
      byp_out_ready = 1'b0; rtr_inj_ready = 1'b1;
      #1;
      check("R2 ej valid", ni_ej_valid, 1'b1);
      check("R2 ej data", ni_ej_data, {1'b1, 33'h0AB1});
      check("R2 in ready", byp_in_ready, 1'b1);
      check("R2 rtr_ej_ready", rtr_ej_ready, 1'b0);
      check("R3 out valid", byp_out_valid, 1'b1);
      check("R3 out data", byp_out_data, {1'b1, 33'h0CD2});
      check("R3 inj ready follows ring", ni_inj_ready, 1'b0);
      check("R3 rtr_inj idle", rtr_inj_valid, 1'b0);
      byp_in_valid = 1'b0; ni_ej_ready = 1'b0; rtr_inj_ready = 1'b0;

      // R8: open a ring injection packet while OFF, then wake
      ni_inj_data = {1'b0, 33'h0111}; byp_out_ready = 1'b1;
      @(negedge clk);
      ni_inj_valid = 1'b0; byp_out_ready = 1'b0;
      align();
      run_window(1'b0, 32);
      check("R4 wake full window", pwr_state, S_WAKE);
      byp_in_valid = 1'b1; byp_in_data = {1'b1, 33'h0222};
      ni_inj_valid = 1'b1; ni_inj_data = {1'b0, 33'h0333};
      #1;
      check("R2 ring ejection while waking", ni_ej_valid, 1'b1);
      check("R3 ring injection while waking", byp_out_valid, 1'b1);
      byp_in_valid = 1'b0; ni_inj_valid = 1'b0;
      repeat (WAKE) @(negedge clk);
      check("R6 on after wake", pwr_state, S_ON);
      ni_inj_valid = 1'b1; ni_inj_data = {1'b0, 33'h0444};
      rtr_ej_valid = 1'b1; rtr_ej_data = {1'b1, 33'h0555}; ni_ej_ready = 1'b1;
      byp_in_valid = 1'b1;
      #1;
      check("R8 open packet stays on ring", byp_out_valid, 1'b1);
      check("R8 router input held", rtr_inj_valid, 1'b0);
      check("R7 ejection from router", ni_ej_data, {1'b1, 33'h0555});
      check("R7 ring input not ready", byp_in_ready, 1'b0);
      byp_in_valid = 1'b0;
      ni_inj_data = {1'b1, 33'h0666}; byp_out_ready = 1'b1;
      @(negedge clk);
      rtr_ej_valid = 1'b0; byp_out_ready = 1'b0; ni_ej_ready = 1'b0;
      #1;
      check("R7 injection to router after tail", rtr_inj_valid, 1'b1);
      check("R7 ring output idle", byp_out_valid, 1'b0);
      check("R7 router data", rtr_inj_data, {1'b1, 33'h0666});

      // R9: open router-side packet blocks power-off
      ni_inj_data = {1'b0, 33'h0777}; rtr_inj_ready = 1'b1;
      @(negedge clk);
      ni_inj_valid = 1'b0; rtr_empty = 1'b1;
      @(negedge clk);
      check("R9 open packet keeps on", pwr_state, S_ON);
      ni_inj_valid = 1'b1; ni_inj_data = {1'b1, 33'h0888};
      @(negedge clk);
      check("R9 transfer cycle keeps on", pwr_state, S_ON);
      ni_inj_valid = 1'b0; rtr_inj_ready = 1'b0;
      @(negedge clk);
      check("R9 off when quiet", pwr_state, S_OFF);
      rtr_empty = 1'b0;

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      done = 1'b1;
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual timeout expected completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule